// File: doc/BRIEF.md
# Soft Volume and Mute Ramp Controller

This block sets the attenuation for the two channels of a stereo DAC datapath. Software gives a target attenuation for each channel in 0.5 dB codes, along with a soft-ramp enable, a ramp pace selector and a mute bit per channel. Hardware gives an active-low soft-mute line. The block watches the signed sample stream and its frame strobe. It reports the attenuation code that the downstream gain stage must apply now, and a flag per channel that shows a change is still in progress.

With soft ramping on, each channel moves one code at a time toward its effective target. Steps come at a fixed pace of frames. With soft ramping off, a channel waits for a zero crossing in its own sample data and then jumps to the target in one step. If no crossing comes, a coarse timeout forces the jump. Any mute source (the per-channel bit or the hardware line) turns the effective target into the mute code and uses whichever of the two methods is selected. The gain multiplication and the register access live elsewhere.

Top module: `atten_ramp_top`

## Requirements
- R1: After reset, both attenuation outputs are 0 and both pending flags are low while the targets are 0.
- R2: Attenuation is an 8-bit code. Code 0 is no attenuation, each code adds 0.5 dB and 255 means muted. A channel held at 255 by a mute stays at 255 and never wraps.
- R3: With soft mode on, a channel that differs from its effective target moves exactly one code toward it on each pace tick. A pace tick is a frame strobe whose 1-based count since reset is a multiple of the pace length.
- R4: The 2-bit rate field picks the pace length: 0 gives 4 frames, 1 gives 16 frames, and 2 or 3 give 32 frames.
- R5: With soft mode off, a channel loads its effective target in a single step on a frame strobe whose sample is a zero crossing. A zero crossing is a sample equal to zero, or a sample whose sign bit differs from the sign bit of the channel's previous sample. Before the first sample, the previous sign counts as non-negative.
- R6: A free-running timeout tick occurs on strobes 512, 1024, 2048 and so on since reset. With soft mode off, a change not yet applied is armed by the first tick that finds it pending and forced by the next tick. The forced jump therefore comes 512 to 1024 frames after the request.
- R7: The channels are independent. A zero crossing on one channel never updates the other.
- R8: The pending flag of a channel is high exactly when its attenuation differs from its effective target.
- R9: Driving the soft-mute input low makes the effective target 255 on both channels. Raising it restores the programmed targets, and the output returns to them by the selected method.
- R10: The left and right mute bits each force only their own channel's effective target to 255.
- R11: A new target written during a soft ramp continues from the current code on the running pace, without restarting the ramp.
- R12: Attenuation outputs change only on clock edges where the frame strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleStb | input | 1 | One-cycle frame strobe; samples valid |
| sampleL | input | 20 | Left signed sample |
| sampleR | input | 20 | Right signed sample |
| targetL | input | 8 | Left programmed attenuation code |
| targetR | input | 8 | Right programmed attenuation code |
| rateSel | input | 2 | Soft ramp pace selector |
| softEn | input | 1 | 1 = gradual ramp, 0 = zero-crossing jump |
| muteL | input | 1 | Left software mute |
| muteR | input | 1 | Right software mute |
| softMuteN | input | 1 | Hardware mute, active low, both channels |
| attenL | output | 8 | Left applied attenuation code |
| attenR | output | 8 | Right applied attenuation code |
| pendL | output | 1 | Left change pending |
| pendR | output | 1 | Right change pending |

## Verification
The hardest case to reach is the timeout fallback. It only appears when no crossing comes for hundreds of frames, and its delay depends on where the request falls within the 512-frame tick period. The stimulus holds both channels at a constant positive sample and issues requests at chosen frame counts, including one just before a tick. It then steps through more than a thousand frames, so that both the long and the short ends of the window are checked frame by frame against an arithmetic model of the tick schedule.

// File: rtl/atten_ramp_pkg.sv
package atten_ramp_pkg;
  localparam int NUM_CH = 2;

  // Per-channel command from control to datapath
  typedef struct packed {
    logic load;  // jump to effective target
    logic inc;   // one code more attenuation
    logic dec;   // one code less attenuation
  } chanStrobe_t;
endpackage

// File: rtl/atten_ramp_dp.sv
module atten_ramp_dp
  import atten_ramp_pkg::*;
#(
  parameter int ATTEN_W  = 8,
  parameter int SAMPLE_W = 20
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 sampleStb,
  input  logic [NUM_CH-1:0][SAMPLE_W-1:0]      samples,
  input  logic [NUM_CH-1:0][ATTEN_W-1:0]       targets,
  input  logic [NUM_CH-1:0]                    muteCh,
  input  logic                                 hwMuteN,
  input  chanStrobe_t [NUM_CH-1:0]             strb,
  output logic [NUM_CH-1:0][ATTEN_W-1:0]       atten,
  output logic [NUM_CH-1:0]                    needUp,
  output logic [NUM_CH-1:0]                    needDown,
  output logic [NUM_CH-1:0]                    pend,
  output logic [NUM_CH-1:0]                    zeroCross
);
  localparam logic [ATTEN_W-1:0] MUTE_CODE = {ATTEN_W{1'b1}};

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic [ATTEN_W-1:0]  effTgt;
    logic [SAMPLE_W-1:0] curSample;
    logic                prevNeg;
    logic                curNeg;
    logic                isZero;

    assign curSample = samples[ch];
    assign curNeg    = curSample[SAMPLE_W-1];
    assign isZero    = (curSample == '0);
    assign effTgt    = (muteCh[ch] || !hwMuteN) ? MUTE_CODE : targets[ch];

    // Zero-crossing detector: zero sample or sign flip versus last frame
    assign zeroCross[ch] = sampleStb && (isZero || (curNeg != prevNeg));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        prevNeg <= 1'b0;
      end else if (sampleStb) begin
        prevNeg <= curNeg;
      end
    end

    // Applied attenuation register
    always_ff @(posedge clk) begin
      if (!rstN) begin
        atten[ch] <= '0;
      end else if (strb[ch].load) begin
        atten[ch] <= effTgt;
      end else if (strb[ch].inc) begin
        atten[ch] <= atten[ch] + ATTEN_W'(1);
      end else if (strb[ch].dec) begin
        atten[ch] <= atten[ch] - ATTEN_W'(1);
      end
    end

    assign needUp[ch]   = (atten[ch] < effTgt);
    assign needDown[ch] = (atten[ch] > effTgt);
    assign pend[ch]     = needUp[ch] || needDown[ch];

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strb[ch].load, strb[ch].inc, strb[ch].dec})); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (atten[ch] == MUTE_CODE) |-> !strb[ch].inc); // R2
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
      (atten[ch] == '0) |-> !strb[ch].dec); // R2
    AST_STEP_TOWARD: assert property (@(posedge clk) disable iff (!rstN)
      strb[ch].inc |-> (atten[ch] < effTgt)); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      !sampleStb |=> $stable(atten[ch])); // R12
  end
endmodule

// File: rtl/atten_ramp_ctrl.sv
module atten_ramp_ctrl
  import atten_ramp_pkg::*;
#(
  parameter int TICK_LEN   = 512,
  parameter int PACE_FAST  = 4,
  parameter int PACE_MID   = 16,
  parameter int PACE_SLOW  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sampleStb,
  input  logic                     softEn,
  input  logic [1:0]               rateSel,
  input  logic [NUM_CH-1:0]        needUp,
  input  logic [NUM_CH-1:0]        needDown,
  input  logic [NUM_CH-1:0]        zeroCross,
  output chanStrobe_t [NUM_CH-1:0] strb
);
  localparam int PACE_W = $clog2(PACE_SLOW + 1);
  localparam int TO_W   = $clog2(TICK_LEN);

  logic [PACE_W-1:0] paceCnt;
  logic [PACE_W-1:0] paceLimit;
  logic              paceWrap;
  logic              paceTick;
  logic [TO_W-1:0]   toCnt;
  logic              toTick;

  always_comb begin
    unique case (rateSel)
      2'd0:    paceLimit = PACE_W'(PACE_FAST);
      2'd1:    paceLimit = PACE_W'(PACE_MID);
      default: paceLimit = PACE_W'(PACE_SLOW);
    endcase
  end

  // Shared pace counter: one tick every paceLimit frames
  assign paceWrap = (paceCnt >= paceLimit - PACE_W'(1));
  assign paceTick = sampleStb && paceWrap;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      paceCnt <= '0;
    end else if (sampleStb) begin
      paceCnt <= paceWrap ? '0 : paceCnt + PACE_W'(1);
    end
  end

  // Free-running timeout tick
  assign toTick = sampleStb && (toCnt == TO_W'(TICK_LEN - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      toCnt <= '0;
    end else if (sampleStb) begin
      toCnt <= toTick ? '0 : toCnt + TO_W'(1);
    end
  end

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic pending;
    logic armed;
    logic doLoad;

    assign pending = needUp[ch] || needDown[ch];
    assign doLoad  = !softEn && sampleStb && pending &&
                     (zeroCross[ch] || (toTick && armed));

    assign strb[ch].load = doLoad;
    assign strb[ch].inc  = softEn && paceTick && needUp[ch];
    assign strb[ch].dec  = softEn && paceTick && needDown[ch];

    // Armed by the first timeout tick seen while a jump waits
    always_ff @(posedge clk) begin
      if (!rstN) begin
        armed <= 1'b0;
      end else if (softEn || !pending || doLoad) begin
        armed <= 1'b0;
      end else if (toTick) begin
        armed <= 1'b1;
      end
    end

    AST_ZC_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
      zeroCross[ch] |-> sampleStb); // R5
    AST_DIR_EXCL: assert property (@(posedge clk) disable iff (!rstN)
      !(needUp[ch] && needDown[ch])); // R8
  end

  AST_TICK_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (toTick || paceTick) |-> sampleStb); // R6
endmodule

// File: rtl/atten_ramp_top.sv
module atten_ramp_top
  import atten_ramp_pkg::*;
#(
  parameter int ATTEN_W  = 8,
  parameter int SAMPLE_W = 20,
  parameter int TICK_LEN = 512
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleStb,
  input  logic [SAMPLE_W-1:0] sampleL,
  input  logic [SAMPLE_W-1:0] sampleR,
  input  logic [ATTEN_W-1:0]  targetL,
  input  logic [ATTEN_W-1:0]  targetR,
  input  logic [1:0]          rateSel,
  input  logic                softEn,
  input  logic                muteL,
  input  logic                muteR,
  input  logic                softMuteN,
  output logic [ATTEN_W-1:0]  attenL,
  output logic [ATTEN_W-1:0]  attenR,
  output logic                pendL,
  output logic                pendR
);
  chanStrobe_t [NUM_CH-1:0]           strb;
  logic [NUM_CH-1:0][ATTEN_W-1:0]     atten;
  logic [NUM_CH-1:0]                  needUp;
  logic [NUM_CH-1:0]                  needDown;
  logic [NUM_CH-1:0]                  pend;
  logic [NUM_CH-1:0]                  zeroCross;

  atten_ramp_dp #(
    .ATTEN_W  (ATTEN_W),
    .SAMPLE_W (SAMPLE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .samples   ({sampleR, sampleL}),
    .targets   ({targetR, targetL}),
    .muteCh    ({muteR, muteL}),
    .hwMuteN   (softMuteN),
    .strb      (strb),
    .atten     (atten),
    .needUp    (needUp),
    .needDown  (needDown),
    .pend      (pend),
    .zeroCross (zeroCross)
  );

  atten_ramp_ctrl #(
    .TICK_LEN (TICK_LEN)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .sampleStb (sampleStb),
    .softEn    (softEn),
    .rateSel   (rateSel),
    .needUp    (needUp),
    .needDown  (needDown),
    .zeroCross (zeroCross),
    .strb      (strb)
  );

  assign attenL = atten[0];
  assign attenR = atten[1];
  assign pendL  = pend[0];
  assign pendR  = pend[1];
endmodule

// File: tb/atten_ramp_top_tb.sv
module atten_ramp_top_tb;
  logic              clk = 1'b0;
  logic              rstN;
  logic              sampleStb;
  logic [19:0]       sampleL, sampleR;
  logic [7:0]        targetL, targetR;
  logic [1:0]        rateSel;
  logic              softEn, muteL, muteR, softMuteN;
  logic [7:0]        attenL, attenR;
  logic              pendL, pendR;

  int checks = 0;
  int fails  = 0;

  // Bench model state
  int  frameNo;
  int  expA [2];
  bit  armedM [2];
  bit  prevNegM [2];

  always #4 clk = ~clk;

  atten_ramp_top u_dut (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb),
    .sampleL(sampleL), .sampleR(sampleR),
    .targetL(targetL), .targetR(targetR), .rateSel(rateSel),
    .softEn(softEn), .muteL(muteL), .muteR(muteR), .softMuteN(softMuteN),
    .attenL(attenL), .attenR(attenR), .pendL(pendL), .pendR(pendR)
  );

  function automatic int paceLen();
    return (rateSel == 2'd0) ? 4 : (rateSel == 2'd1) ? 16 : 32;
  endfunction

  function automatic int effTarget(int ch);
    if (!softMuteN) return 255;
    if (ch == 0) return muteL ? 255 : int'(targetL);
    return muteR ? 255 : int'(targetR);
  endfunction

  task automatic checkVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s frame %0d: actual %0d expected %0d", req, what, frameNo, act, exp);
    end
  endtask

  task automatic checkAll(string req);
    checkVal(req, "attenL", int'(attenL), expA[0]);
    checkVal(req, "attenR", int'(attenR), expA[1]);
    checkVal("R8", "pendL", int'(pendL), int'(expA[0] != effTarget(0)));
    checkVal("R8", "pendR", int'(pendR), int'(expA[1] != effTarget(1)));
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; sampleStb = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    frameNo = 0;
    for (int c = 0; c < 2; c++) begin
      expA[c] = 0; armedM[c] = 1'b0; prevNegM[c] = 1'b0;
    end
  endtask

  // One frame: drive, let the edge pass, advance the model, compare
  task automatic frame(logic [19:0] sL, logic [19:0] sR, string req);
    bit zc, paceT, toT;
    int eff;
    logic [19:0] s;
    @(negedge clk);
    sampleL = sL; sampleR = sR; sampleStb = 1'b1;
    @(negedge clk);
    sampleStb = 1'b0;
    frameNo++;
    paceT = (frameNo % paceLen()) == 0;
    toT   = (frameNo % 512) == 0;
    for (int c = 0; c < 2; c++) begin
      s   = (c == 0) ? sL : sR;
      eff = effTarget(c);
      zc  = (s == 20'd0) || (s[19] != prevNegM[c]);
      prevNegM[c] = s[19];
      if (softEn) begin
        armedM[c] = 1'b0;
        if (paceT && expA[c] < eff) expA[c]++;
        else if (paceT && expA[c] > eff) expA[c]--;
      end else if (expA[c] != eff) begin
        if (zc || (toT && armedM[c])) begin
          expA[c] = eff; armedM[c] = 1'b0;
        end else if (toT) armedM[c] = 1'b1;
      end else armedM[c] = 1'b0;
    end
    checkAll(req);
  endtask

  task automatic frames(int n, logic [19:0] sL, logic [19:0] sR, string req);
    for (int i = 0; i < n; i++) frame(sL, sR, req);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rstN = 1'b0; sampleStb = 1'b0; sampleL = '0; sampleR = '0;
    targetL = '0; targetR = '0; rateSel = 2'd0;
    softEn = 1'b1; muteL = 1'b0; muteR = 1'b0; softMuteN = 1'b1;

    // Reset state
    doReset();
    @(negedge clk);
    checkAll("R1");

    // Soft ramp sweep over all rate codes, with a retarget mid-ramp
    for (int r = 0; r < 4; r++) begin
      rateSel = 2'(r); softEn = 1'b1; targetL = 8'd0; targetR = 8'd0;
      doReset();
      targetL = 8'd9; targetR = 8'd3;
      frames(5 * paceLen(), 20'd100, 20'd200, "R3/R4");
      targetL = 8'd2;
      frames(6 * paceLen(), 20'd100, 20'd200, "R11");
      targetR = 8'd0;
      frames(4 * paceLen(), 20'd100, 20'd200, "R3");
    end

    // Hard mode: zero crossing per channel, sign flip and zero sample
    rateSel = 2'd0; softEn = 1'b0; targetL = 8'd0; targetR = 8'd0;
    doReset();
    targetL = 8'd40; targetR = 8'd60;
    frames(10, 20'd5, 20'd7, "R5");
    frame(20'hFFFFB, 20'd7, "R7");
    frame(20'd3, 20'd0, "R5");
    frames(3, 20'd3, 20'd9, "R5");

    // Timeout fallback: long window and short window
    targetL = 8'd0; targetR = 8'd0;
    doReset();
    frames(100, 20'd50, 20'd50, "R6");
    targetL = 8'd77;
    frames(411, 20'd50, 20'd50, "R6");
    targetR = 8'd30;
    frames(600, 20'd50, 20'd50, "R6");
    targetL = 8'd5;
    frames(990, 20'd50, 20'd50, "R6");

    // Hardware soft mute, down to 255 and back
    softEn = 1'b1; rateSel = 2'd0; targetL = 8'd0; targetR = 8'd0;
    doReset();
    targetL = 8'd6; targetR = 8'd10;
    frames(50, 20'd1, 20'd1, "R9");
    softMuteN = 1'b0;
    frames(1050, 20'd1, 20'd1, "R9");
    frames(20, 20'd1, 20'd1, "R2");
    checkVal("R2", "attenL at mute", int'(attenL), 255);
    softMuteN = 1'b1;
    frames(1050, 20'd1, 20'd1, "R9");

    // Software mute per channel, hard then soft
    softEn = 1'b0; targetL = 8'd0; targetR = 8'd0;
    doReset();
    targetL = 8'd4; targetR = 8'd8;
    frame(20'hFFFF0, 20'hFFFF0, "R5");
    muteL = 1'b1;
    frame(20'd16, 20'd16, "R10");
    checkVal("R10", "attenR kept", int'(attenR), 8);
    muteL = 1'b0; muteR = 1'b1; softEn = 1'b1;
    frames(60, 20'd16, 20'd16, "R10");

    // No strobe, no change
    muteR = 1'b0; softEn = 1'b0; targetL = 8'd120;
    repeat (6) @(negedge clk);
    checkAll("R12");
    frame(20'd0, 20'd16, "R12");

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule